// File: doc/BRIEF.md
# Banked 24-bit Colour Palette with Index Mask

This block is a 256-entry colour lookup table for a display pipeline. Software or a coprocessor updates it through a narrow window of 32 colour registers. A 3-bit bank value in a control register picks which group of 32 entries the window reaches. A half-select bit in the same register picks whether a 12-bit write fills the upper or the lower half of the 24-bit entry. The two halves sit in two separate memories.

On the display side, pixels arrive as an 8-bit index, one bit from each of eight bitplanes, on a valid/ready stream. Each index is XORed with an 8-bit mask from the control register, the result addresses both memories, and the colour leaves one cycle later on a second valid/ready stream. That stream carries a 12-bit display colour (4 bits each of red, green and blue, taken from the upper half) and the full 24-bit entry. Back-pressure: an input pixel is taken only on a cycle where `pix_valid` and `pix_ready` are both high. `pix_ready` is high whenever the output register is empty or is being drained in the same cycle. A presented colour stays unchanged until `out_ready` takes it.

Top module: `banked_palette`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0 and `pix_ready` is 1. Reset sets bank 0, half-select upper (0) and mask 0x00.
- R2: A colour write (`reg_we`=1) stores `reg_data` into entry `bank*32 + reg_num`. `bank` is the value held in the control register on that clock edge.
- R3: When `cfg_half`=0 is held, a colour write replaces bits 23:12 of the entry. When `cfg_half`=1 is held, it replaces bits 11:0. The other 12 bits of the entry keep their value.
- R4: An accepted pixel `pix_planes` (bit n from bitplane n) reads entry `pix_planes ^ mask`.
- R5: A pixel accepted at clock edge k is presented with `out_valid`=1 after edge k+1. `out_valid` never rises without an accepted pixel.
- R6: `out_full24` is the whole 24-bit entry. `out_rgb12` equals bits 23:12 of the entry: red in [11:8], green in [7:4], blue in [3:0].
- R7: While `out_valid`=1 and `out_ready`=0, `pix_ready` is 0, and the output holds its valid and its data into the next cycle.
- R8: A pixel accepted on the same edge as a colour write to the entry it reads returns the entry's value from before that write.
- R9: `cfg_we`=1 loads bank, half-select and mask together. A colour write or pixel on the same edge uses the values held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the control register |
| cfg_bank | input | 3 | Bank reached by the register window |
| cfg_half | input | 1 | 0: writes fill the upper 12 bits, 1: the lower 12 bits |
| cfg_mask | input | 8 | XOR mask applied to pixel indices |
| reg_we | input | 1 | Colour register write strobe |
| reg_num | input | 5 | Colour register number within the window |
| reg_data | input | 12 | Colour half-entry data |
| pix_valid | input | 1 | Pixel index valid |
| pix_ready | output | 1 | Pixel index accepted when high together with valid |
| pix_planes | input | 8 | Pixel index, bit n from bitplane n |
| out_valid | output | 1 | Colour valid |
| out_ready | input | 1 | Downstream accepts the colour |
| out_rgb12 | output | 12 | Display colour, 4:4:4 RGB |
| out_full24 | output | 24 | Complete palette entry |

## Verification
The first read pass sweeps all 256 indices with a zero mask after every bank and half has been filled with distinct values. A wrong bank shift or a swapped half shows up as a mismatch here. A second sweep with mask 0xA5 separates masking from plain addressing. Rewriting lower halves only shows whether the upper bits bleed. A sweep under a pseudo-random `out_ready` pattern exposes lost, duplicated or changing outputs while stalled. Directed same-edge cases check the read-before-write order and the moment at which a control load takes effect.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;

  localparam int unsigned HALVES = 2;
endpackage

// File: rtl/pal_ctrl_reg.sv
module pal_ctrl_reg
  import pal_pkg::*;
#(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic              cfg_half,
  input  logic [IDX_W-1:0]  cfg_mask,
  output logic [BANK_W-1:0] bank_q,
  output half_e             half_q,
  output logic [IDX_W-1:0]  mask_q
);
  // All three fields load together; a load is seen one edge later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      half_q <= HALF_UPPER;
      mask_q <= '0;
    end else if (cfg_we) begin
      bank_q <= cfg_bank;
      half_q <= half_e'(cfg_half);
      mask_q <= cfg_mask;
    end
  end
endmodule

// File: rtl/pal_wr_decode.sv
module pal_wr_decode
  import pal_pkg::*;
#(
  parameter int unsigned WIN_W  = 5,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned IDX_W = WIN_W + BANK_W
) (
  input  logic              reg_we,
  input  logic [WIN_W-1:0]  reg_num,
  input  logic [BANK_W-1:0] bank_q,
  input  half_e             half_q,
  output logic [IDX_W-1:0]  waddr,
  output logic              we_upper,
  output logic              we_lower
);
  // Bank occupies the high address bits: entry = bank * 2**WIN_W + reg_num.
  always_comb begin
    waddr    = {bank_q, reg_num};
    we_upper = reg_we && (half_q == HALF_UPPER);
    we_lower = reg_we && (half_q == HALF_LOWER);
  end
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 12,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Read and write share an edge; the read sees the pre-write contents.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_pix_stage.sv
module pal_pix_stage #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_planes,
  input  logic [IDX_W-1:0] mask_q,
  input  logic             out_ready,
  output logic             pix_ready,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             out_valid
);
  always_comb begin
    pix_ready = !out_valid || out_ready;
    rd_en     = pix_valid && pix_ready;
    rd_addr   = pix_planes ^ mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (pix_ready) out_valid <= pix_valid;
  end
endmodule

// File: rtl/banked_palette.sv
module banked_palette
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned WIN_W  = 5,
  parameter int unsigned HALF_W = 12,
  localparam int unsigned BANK_W = IDX_W - WIN_W,
  localparam int unsigned FULL_W = HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic              cfg_half,
  input  logic [IDX_W-1:0]  cfg_mask,
  input  logic              reg_we,
  input  logic [WIN_W-1:0]  reg_num,
  input  logic [HALF_W-1:0] reg_data,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [IDX_W-1:0]  pix_planes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W-1:0] out_rgb12,
  output logic [FULL_W-1:0] out_full24
);
  logic [BANK_W-1:0] bank_q;
  half_e             half_q;
  logic [IDX_W-1:0]  mask_q;
  logic [IDX_W-1:0]  waddr;
  logic              we_upper, we_lower;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_addr;
  logic              we_half [HALVES];
  logic [HALF_W-1:0] rd_half [HALVES];

  pal_ctrl_reg #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_half(cfg_half), .cfg_mask(cfg_mask),
    .bank_q(bank_q), .half_q(half_q), .mask_q(mask_q)
  );

  pal_wr_decode #(.WIN_W(WIN_W), .BANK_W(BANK_W)) u_dec (
    .reg_we(reg_we), .reg_num(reg_num), .bank_q(bank_q), .half_q(half_q),
    .waddr(waddr), .we_upper(we_upper), .we_lower(we_lower)
  );

  pal_pix_stage #(.IDX_W(IDX_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_planes(pix_planes),
    .mask_q(mask_q), .out_ready(out_ready), .pix_ready(pix_ready),
    .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid)
  );

  assign we_half[0] = we_upper;
  assign we_half[1] = we_lower;

  // Slot 0 holds the upper half of every entry, slot 1 the lower half.
  for (genvar g = 0; g < HALVES; g++) begin : g_half
    pal_ram #(.AW(IDX_W), .DW(HALF_W)) u_ram (
      .clk(clk), .we(we_half[g]), .waddr(waddr), .wdata(reg_data),
      .re(rd_en), .raddr(rd_addr), .rdata(rd_half[g])
    );
  end

  assign out_full24 = {rd_half[0], rd_half[1]};
  assign out_rgb12  = rd_half[0];
endmodule

// File: rtl/palette_checks.sv
module palette_checks #(
  parameter int unsigned FULL_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FULL_W-1:0] out_full24
);
  AST_EMPTY_IN_RESET: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1

  AST_PRESENT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> out_valid); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pix_valid && pix_ready)); // R5

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !pix_ready); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_full24)); // R7
endmodule

bind banked_palette palette_checks #(.FULL_W(FULL_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_full24(out_full24)
);

// File: tb/tb_banked_palette.sv
module tb_banked_palette;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bank = '0;
  logic        cfg_half = 1'b0;
  logic [7:0]  cfg_mask = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_num = '0;
  logic [11:0] reg_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_planes = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_rgb12;
  logic [23:0] out_full24;

  banked_palette dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [23:0] model [256];
  logic [2:0]  m_bank = '0;
  logic        m_half = 1'b0;
  logic [7:0]  m_mask = '0;
  logic [23:0] q_exp [$];
  string       q_tag [$];
  bit          bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [11:0] hi_val(int a);
    return 12'((a * 37 + 5) & 12'hFFF);
  endfunction
  function automatic logic [11:0] lo_val(int a, int salt);
    return 12'(((a * 91 + 60) ^ (12'h5A5 + salt)) & 12'hFFF);
  endfunction

  task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  // All driving tasks start and end one time unit after a rising edge.
  task automatic cfg(logic [2:0] b, logic h, logic [7:0] m);
    cfg_we = 1'b1; cfg_bank = b; cfg_half = h; cfg_mask = m;
    @(posedge clk);
    m_bank = b; m_half = h; m_mask = m;
    #1 cfg_we = 1'b0;
  endtask

  task automatic wr(logic [4:0] n, logic [11:0] d);
    logic [7:0] a;
    logic       h;
    a = {m_bank, n};
    h = m_half;
    reg_we = 1'b1; reg_num = n; reg_data = d;
    @(posedge clk);
    if (h == 1'b0) model[a][23:12] = d;
    else           model[a][11:0]  = d;
    #1 reg_we = 1'b0;
  endtask

  task automatic send(logic [7:0] idx, string tag);
    pix_valid = 1'b1; pix_planes = idx;
    @(negedge clk);
    while (!pix_ready) begin
      @(posedge clk); #1;
      @(negedge clk);
    end
    q_exp.push_back(model[idx ^ m_mask]);
    q_tag.push_back(tag);
    @(posedge clk);
    #1 pix_valid = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R5 output without pixel", out_full24, 24'h0);
      end else if (out_ready) begin
        logic [23:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(out_full24 == e && out_rgb12 == e[23:12],
              {t, " R6"}, out_full24, e);
      end else begin
        check(out_full24 == q_exp[0], "R7 stalled output", out_full24, q_exp[0]);
      end
    end
  end

  // Downstream ready pattern.
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  task automatic drain();
    while (q_exp.size() != 0 || out_valid) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    @(negedge clk);
    check(!out_valid && pix_ready, "R1 during reset", {22'd0, out_valid, pix_ready}, 24'd1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && pix_ready, "R1 after reset", {22'd0, out_valid, pix_ready}, 24'd1);
    @(posedge clk); #1;

    // R1: defaults are bank 0, upper half, zero mask.
    for (int n = 0; n < 32; n++) wr(5'(n), 12'(12'h800 + n));
    send(8'd5, "R1 default bank/mask");
    send(8'd31, "R1 default bank/mask");
    drain();

    // R2 R3: fill every bank, both halves.
    for (int b = 0; b < 8; b++) begin
      for (int h = 0; h < 2; h++) begin
        cfg(3'(b), 1'(h), 8'h00);
        for (int n = 0; n < 32; n++) begin
          int a = b * 32 + n;
          wr(5'(n), h == 0 ? hi_val(a) : lo_val(a, 0));
        end
      end
    end
    for (int i = 0; i < 256; i++) send(8'(i), "R2 bank addressing");
    drain();

    // R4: XOR mask before lookup.
    cfg(3'd0, 1'b0, 8'hA5);
    for (int i = 0; i < 256; i += 3) send(8'(i), "R4 masked index");
    drain();

    // R3: lower-half rewrite keeps upper bits.
    cfg(3'd4, 1'b1, 8'h00);
    for (int n = 0; n < 32; n++) wr(5'(n), lo_val(128 + n, 7));
    for (int n = 0; n < 32; n++) send(8'(128 + n), "R3 lower half only");
    drain();

    // R5: one-cycle presentation.
    send(8'd200, "R5 latency");
    @(negedge clk);
    check(out_valid == 1'b1, "R5 valid after one edge", {23'd0, out_valid}, 24'd1);
    @(posedge clk); #1;
    drain();

    // R7: back-pressure sweep.
    bp_mode = 1'b1;
    cfg(3'd0, 1'b0, 8'h3C);
    for (int i = 0; i < 256; i += 2) send(8'(i), "R7 back-pressure");
    drain();
    bp_mode = 1'b0;
    repeat (2) @(posedge clk); #1;

    // R8: same-edge write and read of one entry (bank 1, reg 9, mask 0).
    cfg(3'd1, 1'b0, 8'h00);
    fork
      wr(5'd9, 12'hABC);
      send(8'd41, "R8 read-before-write");
    join
    send(8'd41, "R8 new value after write");
    drain();

    // R9: control load on the same edge as a write and a pixel.
    cfg(3'd2, 1'b0, 8'h00);
    fork
      cfg(3'd7, 1'b0, 8'hFF);
      wr(5'd3, 12'h5E7);
      send(8'd67, "R9 old mask on load edge");
    join
    cfg(3'd0, 1'b0, 8'h00);
    send(8'd67, "R9 write used old bank");
    send(8'd227, "R9 new bank untouched");
    drain();

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule